// File: doc/BRIEF.md
# Cascadable Bidirectional Column Loader

This block is the digital front end of a display column driver. It gathers one line of column codes, 240 codes of six bits by default, from an 18-bit bus that carries three codes per clock. A one-hot token passes along 80 group slots and marks which group of three columns takes the current bus word. When the line is complete, a strobe copies it into an output latch whose contents feed the digital-to-analog converters further down the chip.

Several loaders can be chained into one wide row. A direction input picks the fill order. It also decides which of the two start-pulse ports receives the start pulse and which one passes a carry pulse on to the next loader. Each tri-state start pin appears as three separate signals: an input, an output and a drive enable. The strobe is sampled on the shift clock and acts only on its rising edge. Besides latching the line, it clears the token, so bus data that arrives later is ignored until a new start pulse. A synchronous active-low reset stands in for the first strobe that is needed at power-up.

Top module: `col_line_loader`

## Requirements
- R1: The bus word holds three lanes. Lane l occupies bits [6l+5:6l], with the lowest bit of each lane as the code LSB. Each clock edge at which a group is armed writes all three lanes of that edge's bus word into that group.
- R2: With `dir_fwd` high (1 = forward), a pulse on `start_r_in` begins a fill. Successive edges load columns 1-3, 4-6 and so on up to the last column. Lane 0 goes to the lowest-numbered column of each group.
- R3: With `dir_fwd` low, a pulse on `start_l_in` begins a fill. The first edge loads the top three columns (238, 239, 240 by default) and later groups descend toward column 1. Lane 0 still goes to the lowest-numbered column of its group.
- R4: The port that receives the start pulse has its enable low. The other port has its enable high and carries the carry pulse. An output whose enable is low stays low.
- R5: The carry output goes high just after the edge that loads the last group, which is the 80th edge counting the start edge as the first. It stays high for exactly one clock.
- R6: At the first clock edge that samples `strobe` high after sampling it low, the collected line is copied to `col_codes`, and the new values appear after that edge.
- R7: A strobe rising edge clears the token. No load takes place at that edge, and no later data is taken or carry issued until the next start pulse.
- R8: `col_codes` keeps its value between strobe rising edges, even while a new line is being loaded.
- R9: Bus data clocked while no group is armed changes no stored code.
- R10: A start pulse that arrives during a fill restarts the token at the first group of the current direction.
- R11: After reset, `col_codes` is all zero, both start outputs are low and the enables follow `dir_fwd`.
- R12: Holding `strobe` high for many clocks copies the line only once, at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_fwd | input | 1 | Fill direction: 1 forward from column 1, 0 reverse from the last column |
| pix_data | input | LANES*CODE_W (18) | Three column codes per clock |
| start_r_in | input | 1 | Right start port, input side |
| start_r_out | output | 1 | Right start port, output side (carry in reverse direction) |
| start_r_oe | output | 1 | Right start port drive enable |
| start_l_in | input | 1 | Left start port, input side |
| start_l_out | output | 1 | Left start port, output side (carry in forward direction) |
| start_l_oe | output | 1 | Left start port drive enable |
| strobe | input | 1 | Line latch strobe; acts on its sampled rising edge |
| col_codes | output | GROUPS*LANES*CODE_W (1440) | Latched codes, column c at bits [6(c-1)+5:6(c-1)] |

## Verification
A token that is misplaced, doubled or lost shows up only after the next strobe. It appears as codes written to the wrong column group, or as a group that keeps stale data. The carry pulse reveals it sooner: it arrives early, late, twice, or on the wrong port, and the carry cycle falls exactly one clock after the last armed edge. A broken strobe edge detector shows at once as a missed update or as outputs that move while the strobe is held. A load enable that leaks while no group is armed shows only when stray bus data appears after a later strobe.

// File: rtl/cll_pkg.sv
// Shared defaults and the fill-direction type for the column loader.
package cll_pkg;
    localparam int DEF_CODE_W = 6;
    localparam int DEF_LANES  = 3;
    localparam int DEF_GROUPS = 80;

    typedef enum logic {
        FILL_REV = 1'b0,
        FILL_FWD = 1'b1
    } fill_dir_e;
endpackage

// File: rtl/cll_start_ports.sv
// Start-port steering.
// Picks which start port acts as input and which drives the carry.
// Assumes dir_fwd is stable while a fill is in progress.
module cll_start_ports (
    input  logic dir_fwd,
    input  logic start_r_in,
    input  logic start_l_in,
    input  logic carry,
    output logic start_seen,
    output logic start_r_out,
    output logic start_r_oe,
    output logic start_l_out,
    output logic start_l_oe
);
    import cll_pkg::*;

    fill_dir_e dir;
    assign dir = fill_dir_e'(dir_fwd);

    // Route the start input and the carry output according to the direction.
    always_comb begin
        if (dir == FILL_FWD) begin
            start_seen  = start_r_in;
            start_l_oe  = 1'b1;
            start_l_out = carry;
            start_r_oe  = 1'b0;
            start_r_out = 1'b0;
        end else begin
            start_seen  = start_l_in;
            start_r_oe  = 1'b1;
            start_r_out = carry;
            start_l_oe  = 1'b0;
            start_l_out = 1'b0;
        end
    end
endmodule

// File: rtl/cll_token_chain.sv
// Token chain.
// Keeps a one-hot token naming the group to load on the next edge and emits a one-clock carry after the last group.
// Assumes GROUPS >= 2 and a start pulse that is one clock wide.
module cll_token_chain #(
    parameter int GROUPS = cll_pkg::DEF_GROUPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_fwd,
    input  logic              start,
    input  logic              strobe_rise,
    output logic [GROUPS-1:0] load_en,
    output logic              carry
);
    localparam logic [GROUPS-1:0] FIRST_FWD = {{(GROUPS-1){1'b0}}, 1'b1};
    localparam logic [GROUPS-1:0] FIRST_REV = {1'b1, {(GROUPS-1){1'b0}}};

    logic [GROUPS-1:0] armed;

    // Choose the group written at this edge: the strobe blocks, a start restarts.
    always_comb begin
        if (strobe_rise)
            load_en = '0;
        else if (start)
            load_en = dir_fwd ? FIRST_FWD : FIRST_REV;
        else
            load_en = armed;
    end

    // Advance the token one group and flag the carry after the last group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= '0;
            carry <= 1'b0;
        end else begin
            if (strobe_rise)
                armed <= '0;
            else if (dir_fwd)
                armed <= load_en << 1;
            else
                armed <= load_en >> 1;
            carry <= dir_fwd ? load_en[GROUPS-1] : load_en[0];
        end
    end

    // R10: at most one group is armed at any time
    assert_token_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(armed));
    // R7: the strobe edge leaves no group armed
    assert_strobe_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> (armed == '0));
    // R5: the carry pulse is one clock wide
    assert_carry_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);
endmodule

// File: rtl/cll_line_store.sv
// Line store.
// Holds the data register for every group and the output latch copied from it on the strobe edge.
// Assumes load_en has at most one bit set.
module cll_line_store #(
    parameter int CODE_W = cll_pkg::DEF_CODE_W,
    parameter int LANES  = cll_pkg::DEF_LANES,
    parameter int GROUPS = cll_pkg::DEF_GROUPS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LANES*CODE_W-1:0]        pix_data,
    input  logic [GROUPS-1:0]              load_en,
    input  logic                           strobe_rise,
    output logic [GROUPS*LANES*CODE_W-1:0] line_out
);
    localparam int GW = LANES * CODE_W;

    logic [GW-1:0] data_reg  [GROUPS];
    logic [GW-1:0] latch_reg [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        // Capture the bus word when this group is armed; copy to the latch on the strobe edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_reg[g]  <= '0;
                latch_reg[g] <= '0;
            end else begin
                if (load_en[g])
                    data_reg[g] <= pix_data;
                if (strobe_rise)
                    latch_reg[g] <= data_reg[g];
            end
        end

        assign line_out[g*GW +: GW] = latch_reg[g];

        // R9: a group that is not armed keeps its stored codes
        assert_idle_group_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !load_en[g] |=> $stable(data_reg[g]));
        // R8: the latch changes only at a strobe edge
        assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe_rise |=> $stable(latch_reg[g]));
    end
endmodule

// File: rtl/col_line_loader.sv
// Cascadable bidirectional column loader (top).
// Collects one display line of column codes under a token chain and latches it on the strobe's rising edge.
// Assumes strobe and start are synchronous to clk.
module col_line_loader #(
    parameter int CODE_W = cll_pkg::DEF_CODE_W,
    parameter int LANES  = cll_pkg::DEF_LANES,
    parameter int GROUPS = cll_pkg::DEF_GROUPS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           dir_fwd,
    input  logic [LANES*CODE_W-1:0]        pix_data,
    input  logic                           start_r_in,
    output logic                           start_r_out,
    output logic                           start_r_oe,
    input  logic                           start_l_in,
    output logic                           start_l_out,
    output logic                           start_l_oe,
    input  logic                           strobe,
    output logic [GROUPS*LANES*CODE_W-1:0] col_codes
);
    logic              strobe_q;
    logic              strobe_rise;
    logic              start_seen;
    logic              carry;
    logic [GROUPS-1:0] load_en;

    // Remember the last sampled strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else
            strobe_q <= strobe;
    end

    assign strobe_rise = strobe && !strobe_q;

    cll_start_ports u_ports (
        .dir_fwd     (dir_fwd),
        .start_r_in  (start_r_in),
        .start_l_in  (start_l_in),
        .carry       (carry),
        .start_seen  (start_seen),
        .start_r_out (start_r_out),
        .start_r_oe  (start_r_oe),
        .start_l_out (start_l_out),
        .start_l_oe  (start_l_oe)
    );

    cll_token_chain #(.GROUPS(GROUPS)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir_fwd     (dir_fwd),
        .start       (start_seen),
        .strobe_rise (strobe_rise),
        .load_en     (load_en),
        .carry       (carry)
    );

    cll_line_store #(.CODE_W(CODE_W), .LANES(LANES), .GROUPS(GROUPS)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_data    (pix_data),
        .load_en     (load_en),
        .strobe_rise (strobe_rise),
        .line_out    (col_codes)
    );

    // R4: a start port drives high only while its enable is set
    assert_right_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_r_out |-> start_r_oe);
    assert_left_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_l_out |-> start_l_oe);
    // R12: a held strobe gives no second copy
    assert_held_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && strobe_q) |=> $stable(col_codes));
endmodule

// File: tb/sim_col_line_loader.sv
`timescale 1ns/1ps
// Bench: small configuration (4 groups, 12 columns) swept over lines in both directions.
module sim_col_line_loader;
    localparam int CODE_W = 6;
    localparam int LANES  = 3;
    localparam int GROUPS = 4;
    localparam int COLS   = GROUPS * LANES;
    localparam int BW     = LANES * CODE_W;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   dir_fwd = 1'b1;
    logic [BW-1:0]          pix_data = '0;
    logic                   start_r_in = 1'b0;
    logic                   start_l_in = 1'b0;
    logic                   strobe = 1'b0;
    logic                   start_r_out, start_r_oe, start_l_out, start_l_oe;
    logic [COLS*CODE_W-1:0] col_codes;

    logic [CODE_W-1:0] exp_reg [COLS];
    logic [CODE_W-1:0] exp_out [COLS];
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    col_line_loader #(.CODE_W(CODE_W), .LANES(LANES), .GROUPS(GROUPS)) u0 (
        .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .pix_data(pix_data),
        .start_r_in(start_r_in), .start_r_out(start_r_out), .start_r_oe(start_r_oe),
        .start_l_in(start_l_in), .start_l_out(start_l_out), .start_l_oe(start_l_oe),
        .strobe(strobe), .col_codes(col_codes)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [CODE_W-1:0] code_of(input int line, input int k, input int l);
        return CODE_W'(((line * COLS + k * LANES + l) * 5 + 3) % 64);
    endfunction

    task automatic check_cols(input string req);
        for (int c = 0; c < COLS; c++)
            check(col_codes[c*CODE_W +: CODE_W] == exp_out[c], req,
                  int'(col_codes[c*CODE_W +: CODE_W]), int'(exp_out[c]));
    endtask

    function automatic logic carry_pin();
        return dir_fwd ? start_l_out : start_r_out;
    endfunction

    function automatic logic idle_pin();
        return dir_fwd ? start_r_out : start_l_out;
    endfunction

    // Drive n groups of a line. A full fill also checks the carry timing and ends with stray data.
    task automatic fill(input int line, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k > 0) check(carry_pin() == 1'b0, "R5 carry early", int'(carry_pin()), 0);
            start_r_in = dir_fwd && (k == 0);
            start_l_in = !dir_fwd && (k == 0);
            for (int l = 0; l < LANES; l++) begin
                pix_data[l*CODE_W +: CODE_W] = code_of(line, k, l);
                exp_reg[(dir_fwd ? k * LANES : COLS - LANES - k * LANES) + l] = code_of(line, k, l);
            end
        end
        if (n == GROUPS) begin
            @(negedge clk);
            start_r_in = 1'b0;
            start_l_in = 1'b0;
            pix_data = '1;
            check(carry_pin() == 1'b1, {req, " R5 carry high"}, int'(carry_pin()), 1);
            check(idle_pin() == 1'b0, "R4 idle port low", int'(idle_pin()), 0);
            @(negedge clk);
            check(carry_pin() == 1'b0, "R5 carry one clock", int'(carry_pin()), 0);
        end
    endtask

    task automatic pulse_strobe(input string req, input bit release_after);
        @(negedge clk);
        start_r_in = 1'b0;
        start_l_in = 1'b0;
        strobe = 1'b1;
        pix_data = '1;
        for (int c = 0; c < COLS; c++) exp_out[c] = exp_reg[c];
        @(negedge clk);
        check_cols(req);
        if (release_after) strobe = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < COLS; c++) begin exp_reg[c] = '0; exp_out[c] = '0; end
        repeat (3) @(negedge clk);
        // R11: reset state
        check_cols("R11 reset codes");
        check(start_l_oe == 1'b1 && start_r_oe == 1'b0, "R11 enables fwd",
              int'({start_l_oe, start_r_oe}), 2);
        check(start_l_out == 1'b0 && start_r_out == 1'b0, "R11 outputs low",
              int'({start_l_out, start_r_out}), 0);
        rst_n = 1'b1;

        // R1 R2: forward fills; R8 outputs hold while the next line loads
        for (int line = 0; line < 8; line++) begin
            fill(line, GROUPS, "R2 fwd");
            check_cols("R8 hold during fill");
            pulse_strobe("R1 R2 R6 fwd line", 1'b1);
        end

        // R3: reverse fills with swapped port roles (R4)
        @(negedge clk);
        dir_fwd = 1'b0;
        @(negedge clk);
        check(start_r_oe == 1'b1 && start_l_oe == 1'b0, "R4 enables rev",
              int'({start_r_oe, start_l_oe}), 2);
        for (int line = 8; line < 16; line++) begin
            fill(line, GROUPS, "R3 rev");
            pulse_strobe("R3 R6 rev line", 1'b1);
        end

        // R9: stray data with no token, then a fresh strobe copies the unchanged line
        @(negedge clk);
        pix_data = 18'h2AAAA;
        repeat (3) @(negedge clk);
        pulse_strobe("R9 stray data ignored", 1'b1);

        // R7: strobe in mid-fill clears the token and blocks later loads
        dir_fwd = 1'b1;
        fill(20, 2, "R7 partial");
        pulse_strobe("R7 strobe mid-fill", 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pix_data = BW'(i * 4321);
            check(carry_pin() == 1'b0, "R7 no carry after clear", int'(carry_pin()), 0);
        end
        pulse_strobe("R7 no load after clear", 1'b1);

        // R10: restart in mid-fill goes back to the first group
        fill(21, 2, "R10 partial");
        fill(22, GROUPS, "R10 restart");
        pulse_strobe("R10 restart line", 1'b1);
        dir_fwd = 1'b0;
        fill(23, 3, "R10 rev partial");
        fill(24, GROUPS, "R10 rev restart");
        pulse_strobe("R10 rev restart line", 1'b1);

        // R12: strobe held high through a full fill gives no second copy
        pulse_strobe("R12 first edge", 1'b0);
        fill(25, GROUPS, "R12 fill under held strobe");
        check_cols("R12 held strobe no copy");
        @(negedge clk);
        strobe = 1'b0;
        pulse_strobe("R12 new edge copies", 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule